// File: doc/BRIEF.md
# Low-power timer counter source selection

This block is the counting core of a low-power timer. One 16-bit up-counter can be driven from three sources. It can count pulses of the internal clock after a power-of-two prescaler. It can count edges of an external input that the internal clock samples. Or it can use the external input directly as the clock of a small counting kernel, with no internal clock involved. The counter returns to zero once it has reached the reload value. It raises a one-cycle match pulse whenever a step brings it to the compare value.

A run-mode state machine in the internal clock domain picks the source from the enable, source-select and count-mode inputs. Its states are ST_OFF, ST_PULSE, ST_SAMPLE and ST_EXTERN. Every cycle it moves to ST_OFF when enable is low. With enable high it moves to ST_EXTERN when source-select is 1, to ST_SAMPLE when source-select is 0 and count mode is 1, and to ST_PULSE otherwise. Any state can reach any other in one cycle. ST_OFF clears the internal counter and the prescaler.

The external-clock kernel has its own state machine, clocked by the selected edge of the external input. It is held in reset while the block is disabled or is not in external-clock mode. It has two states. KS_WARM absorbs the first five active edges. On the fifth of them the machine takes the transition to KS_RUN, and from then on each active edge is one count step. In ST_EXTERN the outputs come from the kernel; in every other state they come from the internal counter.

Top module: `lpt_counter_src`

## Requirements
- R1: After reset count_o is 0 and match_o is 0. Once enable_i has been low for three consecutive cycles, count_o reads 0.
- R2: In internal-pulse mode (source-select 0, count mode 0), prescaler code n from 0 to 7 makes the counter advance exactly once per 2^n internal clock cycles.
- R3: A step taken while the counter equals reload_i sets it to 0; any other step adds 1.
- R4: match_o is high for one kernel cycle after each step that makes the counter equal compare_i, and count_o equals compare_i whenever match_o is high.
- R5: In sampled mode (source-select 0, count mode 1), the external input passes a two-flop synchronizer. The counter then advances once per detected edge, at the latest four internal cycles after the input changes. Polarity code 00 counts rising edges.
- R6: In sampled mode, polarity code 01 counts only falling edges, code 10 counts both edges and code 11 counts rising edges.
- R7: In sampled mode the prescaler code has no effect: edges are sampled at the full internal clock rate.
- R8: In external-clock mode (source-select 1), the first five active edges after enable leave the counter at 0, and each later active edge adds one.
- R9: In external-clock mode, polarity code 01 makes falling edges active. Codes 00, 10 and 11 make rising edges active, so both-edge counting is not available.
- R10: In external-clock mode the count-mode bit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | 1 | External input: an event source, or the kernel clock |
| enable_i | input | 1 | Counter enable; low clears the counter |
| src_ext_i | input | 1 | Source select: 1 makes ext_i the kernel clock |
| mode_smp_i | input | 1 | Count mode: 1 counts sampled edges of ext_i |
| presc_i | input | 3 | Prescaler code n, division by 2^n |
| pol_i | input | 2 | Edge polarity: 00 rise, 01 fall, 10 both, 11 rise |
| reload_i | input | 16 | Wrap value |
| compare_i | input | 16 | Match value |
| count_o | output | 16 | Counter value of the active source |
| match_o | output | 1 | One-cycle pulse when the counter reaches compare_i |

## Verification
The bench measures the count over windows of exactly k·2^n cycles, so a prescaler that is off by one period gives the wrong difference. In sampled mode it uses patterns whose edge counts differ between rising, falling and both, so a polarity decoder with swapped codes, or one that drops both-edge counting, gives the wrong count. In external-clock mode it checks after exactly five edges and again after more. A kernel that absorbs four or six edges, or that honours both-edge polarity, is off by one or more. It also checks the wrap point, the match pulses in one window, and that changing the count-mode bit and the prescaler code leaves the count unchanged in the modes where they must be ignored.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        POL_RISE = 2'b00,
        POL_FALL = 2'b01,
        POL_BOTH = 2'b10,
        POL_ALT  = 2'b11
    } pol_e;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_PULSE,
        ST_SAMPLE,
        ST_EXTERN
    } run_st_e;

    typedef enum logic {
        KS_WARM,
        KS_RUN
    } kern_st_e;

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             tick_o
);
    localparam int DIV_W = (1 << PSC_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Low code_i bits set: a tick every 2^code_i cycles
    assign mask   = ~({DIV_W{1'b1}} << code_i);
    assign tick_o = run_i && ((div_q & mask) == mask);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= '0;
        end else if (!run_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + {{(DIV_W-1){1'b0}}, 1'b1};
        end
    end
endmodule

// File: rtl/lpt_edge_sampler.sv
module lpt_edge_sampler
    import lpt_pkg::*;
#(
    parameter int SYNC_N = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       din_i,
    input  logic [1:0] pol_i,
    output logic       edge_o
);
    logic [SYNC_N:0] sh_q;
    logic            cur;
    logic            prev;
    logic            rise;
    logic            fall;

    for (genvar i = 0; i <= SYNC_N; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q[0] <= 1'b0;
                else         sh_q[0] <= din_i;
            end
        end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) sh_q[i] <= 1'b0;
                else         sh_q[i] <= sh_q[i-1];
            end
        end
    end

    assign cur  = sh_q[SYNC_N-1];
    assign prev = sh_q[SYNC_N];
    assign rise = cur & ~prev;
    assign fall = ~cur & prev;

    always_comb begin
        unique case (pol_e'(pol_i))
            POL_FALL: edge_o = fall;
            POL_BOTH: edge_o = rise | fall;
            default:  edge_o = rise;
        endcase
    end
endmodule

// File: rtl/lpt_counter.sv
module lpt_counter #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         step_i,
    input  logic [W-1:0] reload_i,
    input  logic [W-1:0] compare_i,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] nxt;

    assign nxt = (cnt_o == reload_i) ? '0 : cnt_o + ONE;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_o   <= '0;
            match_o <= 1'b0;
        end else if (clr_i) begin
            cnt_o   <= '0;
            match_o <= 1'b0;
        end else begin
            match_o <= step_i && (nxt == compare_i);
            if (step_i) cnt_o <= nxt;
        end
    end
endmodule

// File: rtl/lpt_ext_kernel.sv
module lpt_ext_kernel
    import lpt_pkg::*;
#(
    parameter int W   = 16,
    parameter int LAT = 5
) (
    input  logic         ext_i,
    input  logic         fall_sel_i,
    input  logic         rst_ni,
    input  logic [W-1:0] reload_i,
    input  logic [W-1:0] compare_i,
    output logic         kclk_o,
    output logic         warm_o,
    output logic [W-1:0] cnt_o,
    output logic         match_o
);
    localparam int WW = $clog2(LAT + 1);
    localparam logic [WW-1:0] LAST = WW'(LAT - 1);

    kern_st_e      ks_q;
    logic [WW-1:0] wcnt_q;

    // The selected edge of the input becomes a rising kernel clock edge
    assign kclk_o = ext_i ^ fall_sel_i;
    assign warm_o = (ks_q == KS_WARM);

    always_ff @(posedge kclk_o or negedge rst_ni) begin
        if (!rst_ni) begin
            ks_q   <= KS_WARM;
            wcnt_q <= '0;
        end else begin
            unique case (ks_q)
                KS_WARM: begin
                    if (wcnt_q == LAST) ks_q   <= KS_RUN;
                    else                wcnt_q <= wcnt_q + {{(WW-1){1'b0}}, 1'b1};
                end
                KS_RUN: ks_q <= KS_RUN;
            endcase
        end
    end

    lpt_counter #(.W(W)) u_kcnt (
        .clk_i    (kclk_o),
        .rst_ni   (rst_ni),
        .clr_i    (1'b0),
        .step_i   (ks_q == KS_RUN),
        .reload_i (reload_i),
        .compare_i(compare_i),
        .cnt_o    (cnt_o),
        .match_o  (match_o)
    );
endmodule

// File: rtl/lpt_counter_src.sv
module lpt_counter_src
    import lpt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3,
    parameter int SYNC_N = 2,
    parameter int LAT    = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ext_i,
    input  logic             enable_i,
    input  logic             src_ext_i,
    input  logic             mode_smp_i,
    input  logic [PSC_W-1:0] presc_i,
    input  logic [1:0]       pol_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic [CNT_W-1:0] compare_i,
    output logic [CNT_W-1:0] count_o,
    output logic             match_o
);
    run_st_e          st_q;
    run_st_e          st_d;
    logic             pre_run;
    logic             int_clr;
    logic             use_ext;
    logic             tick;
    logic             smp_edge;
    logic             int_step;
    logic [CNT_W-1:0] int_cnt;
    logic             int_match;
    logic [CNT_W-1:0] ext_cnt;
    logic             ext_match;
    logic             ext_warm;
    logic             kclk;
    logic             ext_rst_n;
    logic             fall_sel;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_OFF;
        else         st_q <= st_d;
    end

    // Next state: every state reaches its target in one cycle
    always_comb begin
        if (!enable_i)      st_d = ST_OFF;
        else if (src_ext_i) st_d = ST_EXTERN;
        else if (mode_smp_i) st_d = ST_SAMPLE;
        else                st_d = ST_PULSE;
    end

    // Outputs of the state machine
    always_comb begin
        pre_run  = 1'b0;
        int_clr  = 1'b0;
        use_ext  = 1'b0;
        int_step = 1'b0;
        unique case (st_q)
            ST_OFF: begin
                int_clr = 1'b1;
            end
            ST_PULSE: begin
                pre_run  = 1'b1;
                int_step = tick;
            end
            ST_SAMPLE: begin
                int_step = smp_edge;
            end
            ST_EXTERN: begin
                int_clr = 1'b1;
                use_ext = 1'b1;
            end
        endcase
    end

    lpt_prescaler #(.PSC_W(PSC_W)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .run_i (pre_run),
        .code_i(presc_i),
        .tick_o(tick)
    );

    lpt_edge_sampler #(.SYNC_N(SYNC_N)) u_smp (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (ext_i),
        .pol_i (pol_i),
        .edge_o(smp_edge)
    );

    lpt_counter #(.W(CNT_W)) u_icnt (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .clr_i    (int_clr),
        .step_i   (int_step),
        .reload_i (reload_i),
        .compare_i(compare_i),
        .cnt_o    (int_cnt),
        .match_o  (int_match)
    );

    // The kernel is held in reset unless external-clock mode is enabled
    assign ext_rst_n = rst_ni & enable_i & src_ext_i;
    assign fall_sel  = (pol_e'(pol_i) == POL_FALL);

    lpt_ext_kernel #(.W(CNT_W), .LAT(LAT)) u_kern (
        .ext_i     (ext_i),
        .fall_sel_i(fall_sel),
        .rst_ni    (ext_rst_n),
        .reload_i  (reload_i),
        .compare_i (compare_i),
        .kclk_o    (kclk),
        .warm_o    (ext_warm),
        .cnt_o     (ext_cnt),
        .match_o   (ext_match)
    );

    assign count_o = use_ext ? ext_cnt   : int_cnt;
    assign match_o = use_ext ? ext_match : int_match;
endmodule

// File: rtl/lpt_src_chk.sv
module lpt_src_chk
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             enable_i,
    input logic [CNT_W-1:0] compare_i,
    input logic [CNT_W-1:0] count_o,
    input logic             match_o,
    input run_st_e          st_q,
    input logic             smp_edge,
    input logic             kclk,
    input logic             ext_rst_n,
    input logic             ext_warm,
    input logic [CNT_W-1:0] ext_cnt
);
    // R1
    disable_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!enable_i && $past(!enable_i) && $past(!enable_i, 2)) |-> (count_o == '0));

    // R4
    match_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> (count_o == compare_i));

    // R3
    pulse_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_PULSE && $past(st_q) == ST_PULSE) |->
        (count_o == $past(count_o) || count_o == $past(count_o) + {{(CNT_W-1){1'b0}}, 1'b1}
         || count_o == '0));

    // R5
    sample_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_SAMPLE && $past(st_q) == ST_SAMPLE && count_o != $past(count_o))
        |-> $past(smp_edge));

    // R8
    warm_hold_chk: assert property (@(posedge kclk) disable iff (!ext_rst_n)
        ext_warm |-> (ext_cnt == '0));
endmodule

bind lpt_counter_src lpt_src_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .compare_i(compare_i),
    .count_o  (count_o),
    .match_o  (match_o),
    .st_q     (st_q),
    .smp_edge (smp_edge),
    .kclk     (kclk),
    .ext_rst_n(ext_rst_n),
    .ext_warm (ext_warm),
    .ext_cnt  (ext_cnt)
);

// File: tb/sim_lpt_counter_src.sv
`timescale 1ns/100ps
module sim_lpt_counter_src;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext = 1'b0;
    logic        en = 1'b0;
    logic        src = 1'b0;
    logic        mode = 1'b0;
    logic [2:0]  presc = 3'd0;
    logic [1:0]  pol = 2'b00;
    logic [15:0] reload = 16'hFFFF;
    logic [15:0] compare = 16'hFFFF;
    logic [15:0] count;
    logic        match;

    int n_chk = 0;
    int n_bad = 0;
    int match_seen = 0;
    int match_wrong = 0;
    logic [15:0] c0;

    string tag_q[$];
    int    sel_q[$];
    int    exp_q[$];
    event  chk_ev;

    always #2.5 clk = ~clk;

    lpt_counter_src u0 (
        .clk_i(clk), .rst_ni(rst_n), .ext_i(ext), .enable_i(en),
        .src_ext_i(src), .mode_smp_i(mode), .presc_i(presc), .pol_i(pol),
        .reload_i(reload), .compare_i(compare), .count_o(count), .match_o(match)
    );

    always @(negedge clk) begin
        if (match) begin
            match_seen++;
            if (count != compare) match_wrong++;
        end
    end

    // Monitor: pops expected items and compares them with the design
    initial begin
        forever begin
            @(chk_ev);
            while (tag_q.size() > 0) begin
                automatic string t = tag_q.pop_front();
                automatic int    s = sel_q.pop_front();
                automatic int    e = exp_q.pop_front();
                automatic int    a;
                if (s == 0)      a = int'(count);
                else if (s == 1) a = match_seen;
                else if (s == 2) a = int'(match);
                else             a = match_wrong;
                n_chk++;
                if (a != e) begin
                    n_bad++;
                    $display("FAIL %s: actual %0d expected %0d", t, a, e);
                end
            end
        end
    end

    task automatic expect_val(input string t, input int s, input int e);
        tag_q.push_back(t);
        sel_q.push_back(s);
        exp_q.push_back(e);
        -> chk_ev;
        #0.1;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic pulses(input int n, input int hold);
        for (int i = 0; i < n; i++) begin
            ext = 1'b1; cyc(hold);
            ext = 1'b0; cyc(hold);
        end
    endtask

    task automatic off_cfg(input logic s, input logic m, input logic [2:0] p,
                           input logic [1:0] pl);
        en = 1'b0; cyc(3);
        src = s; mode = m; presc = p; pol = pl;
        cyc(1);
        en = 1'b1; cyc(3);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        expect_val("R1 reset count", 0, 0);
        expect_val("R1 reset match", 2, 0);
        rst_n = 1'b1; cyc(2);

        // R2: windows of k * 2^n cycles
        off_cfg(1'b0, 1'b0, 3'd0, 2'b00);
        c0 = count; cyc(10);
        expect_val("R2 presc 0", 0, int'(c0) + 10);
        off_cfg(1'b0, 1'b0, 3'd2, 2'b00);
        c0 = count; cyc(32);
        expect_val("R2 presc 2", 0, int'(c0) + 8);
        off_cfg(1'b0, 1'b0, 3'd7, 2'b00);
        c0 = count; cyc(384);
        expect_val("R2 presc 7", 0, int'(c0) + 3);
        en = 1'b0; cyc(3);
        expect_val("R1 disable clears", 0, 0);

        // R3: wrap after reload
        reload = 16'd5;
        off_cfg(1'b0, 1'b0, 3'd0, 2'b00);
        c0 = count; cyc(10);
        expect_val("R3 wrap at reload", 0, (int'(c0) + 10) % 6);

        // R4: match pulses
        reload = 16'hFFFF; compare = 16'd20;
        en = 1'b0; cyc(3); match_seen = 0;
        off_cfg(1'b0, 1'b0, 3'd1, 2'b00);
        cyc(60);
        expect_val("R4 single match", 1, 1);
        reload = 16'd3; compare = 16'd0;
        off_cfg(1'b0, 1'b0, 3'd0, 2'b00);
        match_seen = 0; cyc(40);
        expect_val("R4 match per wrap", 1, 10);
        expect_val("R4 count equals compare at match", 3, 0);
        reload = 16'hFFFF; compare = 16'hFFFF;

        // R5 / R6 / R7: sampled mode
        off_cfg(1'b0, 1'b1, 3'd0, 2'b00);
        cyc(2); c0 = count;
        pulses(6, 3); cyc(5);
        expect_val("R5 sampled rising", 0, int'(c0) + 6);
        pol = 2'b01; cyc(2); c0 = count;
        ext = 1'b1; cyc(5);
        expect_val("R6 falling ignores rise", 0, int'(c0));
        ext = 1'b0; cyc(5);
        expect_val("R6 falling counts fall", 0, int'(c0) + 1);
        pol = 2'b10; cyc(2); c0 = count;
        pulses(6, 3); cyc(5);
        expect_val("R6 both edges", 0, int'(c0) + 12);
        pol = 2'b11; cyc(2); c0 = count;
        ext = 1'b1; cyc(5);
        expect_val("R6 code 11 rising", 0, int'(c0) + 1);
        ext = 1'b0; cyc(5);
        pol = 2'b00; presc = 3'd5; cyc(2); c0 = count;
        pulses(4, 3); cyc(5);
        expect_val("R7 prescaler ignored", 0, int'(c0) + 4);

        // R8: first five active edges absorbed
        off_cfg(1'b1, 1'b0, 3'd0, 2'b00);
        pulses(5, 2);
        expect_val("R8 five edges absorbed", 0, 0);
        pulses(3, 2);
        expect_val("R8 counting after warmup", 0, 3);

        // R9: polarity in external-clock mode
        off_cfg(1'b1, 1'b0, 3'd0, 2'b01);
        pulses(7, 2); ext = 1'b1; cyc(2);
        expect_val("R9 falling edges", 0, 2);
        en = 1'b0; cyc(1); ext = 1'b0;
        off_cfg(1'b1, 1'b0, 3'd0, 2'b10);
        pulses(7, 2); ext = 1'b1; cyc(2);
        expect_val("R9 both code is rising", 0, 3);
        en = 1'b0; cyc(1); ext = 1'b0;

        // R10: count mode ignored
        off_cfg(1'b1, 1'b1, 3'd3, 2'b00);
        pulses(8, 2);
        expect_val("R10 count mode ignored", 0, 3);

        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule